// File: doc/BRIEF.md
# Page Write Buffer with In-Page Address Wrap

This block gathers the data bytes of one serial-memory write transaction and puts them into the storage array as a single programming cycle. The bus front end first loads a 15-bit word address, then presents received bytes one at a time with a valid strobe. Each byte lands in a 64-entry staging buffer at the slot selected by the low six address bits and marks that slot dirty. The low six bits then advance and wrap inside the page, while the page number stays fixed. If more than 64 bytes arrive, the newer bytes replace the older ones in the same slots.

When the front end signals the end of the transaction with a commit strobe, the block sweeps all 64 slots in ascending order, one per clock. It drives the array write port only for dirty slots, then raises a one-cycle done pulse and clears every dirty flag. While the sweep and the done cycle last, every input is ignored. If a write-inhibit input is high together with the commit, the buffer is thrown away and done comes at once, with no array write.

The block also owns the shared address pointer. A read-step strobe advances this pointer across the full address space, so that current-address and sequential reads follow on from the last byte accessed.

Top module: `page_wbuf`

## Requirements
- R1: Reset is synchronous and active low. After reset the pointer is 0, busy, done and the array write strobe are low, and no buffer slot is dirty, so a commit right after reset writes nothing.
- R2: A load sets the pointer to the given address. An accepted byte is stored in the slot given by pointer bits [5:0] and marks it dirty. Only bits [5:0] of the pointer then increment, and bits [14:6] stay unchanged.
- R3: An accepted byte at offset 63 (bits [5:0] all ones) moves the pointer to offset 0 of the same page.
- R4: When more than 64 bytes arrive before a commit, each slot holds the newest byte written to it, and the array receives only those newest values.
- R5: The commit strobe (write inhibit low) in an idle cycle starts a sweep of offsets 0 to 63, one per clock. The write strobe is high only for dirty slots, with address {page captured at commit, offset}. The done pulse is high for exactly one cycle, 64 clocks after the commit edge. Addresses that are not dirty are left untouched.
- R6: From the commit edge until done has dropped, the byte valid, load, read-step and commit inputs have no effect, and the pointer holds its value.
- R7: All dirty flags clear at the end of the done cycle, so a following commit with no new bytes writes nothing.
- R8: A commit with write inhibit high writes nothing to the array, raises done on the next cycle and discards all buffered bytes.
- R9: A read step advances the full 15-bit pointer by one, and address 0x7FFF wraps to 0. After a write, the pointer holds the last written address plus one within the page.
- R10: In an idle cycle the inputs take effect in this order of priority: commit, then load, then byte valid, then read step. Only the highest active one acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load the pointer from load_addr |
| load_addr | input | 15 | Starting word address |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received data byte |
| rd_step | input | 1 | Advance the pointer after a byte is read |
| commit | input | 1 | End of write transaction; start programming |
| wr_inhibit | input | 1 | When high with commit, discard instead of writing |
| arr_we | output | 1 | Array write strobe, one byte per clock |
| arr_addr | output | 15 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Sweep or done cycle in progress; inputs ignored |
| done | output | 1 | One-cycle pulse at the end of a commit |
| ptr | output | 15 | Shared address pointer |

## Verification
The bench builds the block with the default parameters: a 15-bit address, a 6-bit page offset and 8-bit data. This gives 512 pages, and random start addresses reach the first and last page and the 0x7FFF pointer rollover. Random byte counts up to well past 64 exercise in-page wrap and slot overwrite, and the array writes are compared with a sparse reference memory after each commit. Directed cases add same-cycle input priority and commits with nothing dirty. They also include inhibited commits, and commits during which every input is toggled at random.

// File: rtl/pwb_pkg.sv
// Package: shared types for the page write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_PROG = 2'd1,
        PW_DONE = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwb_ptr.sv
// Module: pwb_ptr
// Keeps the shared address pointer. A load replaces it. A byte advance
// changes only the in-page offset and wraps inside the page. A read step
// advances the full address. Assumes the enables come already prioritised
// from the controller; the if-chain here keeps the same order anyway.
module pwb_ptr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_en,
    input  logic              step_en,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [PAGE_W-1:0] OFS_ONE  = {{(PAGE_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Pointer register: load, then in-page advance, then full-width step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= load_addr;
        end else if (byte_en) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + OFS_ONE};
        end else if (step_en) begin
            ptr <= ptr + ADDR_ONE;
        end
    end

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && !load_en) |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) // R2
        else $error("page bits moved on byte advance");
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && !load_en && ptr[PAGE_W-1:0] == '1) |=> ptr[PAGE_W-1:0] == '0) // R3
        else $error("offset did not wrap to page start");
    AST_STEP_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !byte_en && ptr == '1) |=> ptr == '0) // R9
        else $error("pointer did not roll over to zero");
endmodule

// File: rtl/pwb_store.sv
// Module: pwb_store
// 64-slot (by default) staging buffer with one dirty flag per slot.
// Writes come from the byte path. The read port is addressed by the sweep
// index. A clear drops every dirty flag and wins over a write in the same
// cycle. Assumes write and clear never coincide in normal use.
module pwb_store #(
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    input  logic              clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_dirty
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  dirty_q;

    // Data slots: newest byte per offset overwrites the older one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    // Dirty flags: set on write, all cleared on clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (clr) begin
            dirty_q <= '0;
        end else if (wr_en) begin
            dirty_q[wr_idx] <= 1'b1;
        end
    end

    // Read port for the commit sweep.
    always_comb begin
        rd_data  = slot_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
    end

    AST_DIRTY_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> dirty_q == '0) // R7
        else $error("dirty flags survived clear");
    AST_DIRTY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> dirty_q[$past(wr_idx)]) // R2
        else $error("written slot not marked dirty");
endmodule

// File: rtl/pwb_ctrl.sv
// Module: pwb_ctrl
// Sequencer. In idle it ranks the inputs (commit, load, byte, step) and
// issues one enable. On commit it captures the page and sweeps every offset
// once, or with inhibit set goes straight to done. Done lasts one cycle and
// clears the dirty flags. Assumes the array takes one byte per clock.
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic                     inhibit,
    input  logic                     load,
    input  logic                     byte_valid,
    input  logic                     step,
    input  logic [ADDR_W-PAGE_W-1:0] cur_page,
    output logic                     load_en,
    output logic                     byte_en,
    output logic                     step_en,
    output logic [PAGE_W-1:0]        scan_idx,
    output logic [ADDR_W-PAGE_W-1:0] prog_page,
    output logic                     scanning,
    output logic                     done,
    output logic                     busy,
    output logic                     clr
);
    localparam logic [PAGE_W-1:0] OFS_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

    pw_state_e state_q;
    logic      idle;

    // Decode state into the outputs the datapath needs.
    always_comb begin
        idle     = (state_q == PW_IDLE);
        scanning = (state_q == PW_PROG);
        done     = (state_q == PW_DONE);
        busy     = !idle;
        clr      = done;
        load_en  = idle && !commit && load;
        byte_en  = idle && !commit && !load && byte_valid;
        step_en  = idle && !commit && !load && !byte_valid && step;
    end

    // State, sweep index and captured page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PW_IDLE;
            scan_idx  <= '0;
            prog_page <= '0;
        end else begin
            case (state_q)
                PW_IDLE: begin
                    if (commit) begin
                        state_q   <= inhibit ? PW_DONE : PW_PROG;
                        scan_idx  <= '0;
                        prog_page <= cur_page;
                    end
                end
                PW_PROG: begin
                    scan_idx <= scan_idx + OFS_ONE;
                    if (scan_idx == '1) state_q <= PW_DONE;
                end
                default: state_q <= PW_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R5
        else $error("done longer than one cycle");
    AST_INHIBIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && commit && inhibit) |=> (done && !scanning)) // R8
        else $error("inhibited commit did not finish at once");
    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && scan_idx != '1) |=> (scanning && scan_idx == $past(scan_idx) + OFS_ONE)) // R5
        else $error("sweep skipped or stalled");
endmodule

// File: rtl/page_wbuf.sv
// Module: page_wbuf (top)
// Page write buffer. It stages bytes for one page, commits the dirty ones
// to the array in one sweep, and keeps the shared address pointer.
// Assumes the bus front end provides clean single-cycle strobes and the
// array accepts one write per clock without back-pressure.
module page_wbuf #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_step,
    input  logic              commit,
    input  logic              wr_inhibit,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ptr
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic              load_en, byte_en, step_en;
    logic              scanning, clr;
    logic [PAGE_W-1:0] scan_idx;
    logic [PG_W-1:0]   prog_page;
    logic [DATA_W-1:0] rd_data;
    logic              rd_dirty;

    pwb_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .inhibit    (wr_inhibit),
        .load       (addr_load),
        .byte_valid (byte_valid),
        .step       (rd_step),
        .cur_page   (ptr[ADDR_W-1:PAGE_W]),
        .load_en    (load_en),
        .byte_en    (byte_en),
        .step_en    (step_en),
        .scan_idx   (scan_idx),
        .prog_page  (prog_page),
        .scanning   (scanning),
        .done       (done),
        .busy       (busy),
        .clr        (clr)
    );

    pwb_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .byte_en   (byte_en),
        .step_en   (step_en),
        .ptr       (ptr)
    );

    pwb_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (byte_en),
        .wr_idx   (ptr[PAGE_W-1:0]),
        .wr_data  (byte_data),
        .rd_idx   (scan_idx),
        .clr      (clr),
        .rd_data  (rd_data),
        .rd_dirty (rd_dirty)
    );

    // Array port: write only dirty slots during the sweep.
    always_comb begin
        arr_we    = scanning && rd_dirty;
        arr_addr  = {prog_page, scan_idx};
        arr_wdata = arr_we ? rd_data : '0;
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr)) // R6
        else $error("pointer moved while busy");
    AST_WE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (busy && !done)) // R5
        else $error("array write outside the sweep");
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !arr_we && ptr == '0)) // R1
        else $error("reset state wrong");
endmodule

// File: tb/page_wbuf_tb.sv
// Bench for page_wbuf: directed corners plus seeded random transactions,
// checked against a sparse reference memory kept by the bench.
module page_wbuf_tb;
    localparam int AW = 15;
    localparam int PW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          rd_step = 1'b0;
    logic          commit = 1'b0;
    logic          wr_inhibit = 1'b0;
    logic          arr_we, busy, done;
    logic [AW-1:0] arr_addr, ptr;
    logic [DW-1:0] arr_wdata;

    always #4 clk = ~clk;  // 125 MHz

    page_wbuf #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .rd_step(rd_step),
        .commit(commit), .wr_inhibit(wr_inhibit), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy), .done(done),
        .ptr(ptr)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    int            wr_cnt = 0;
    logic [DW-1:0] dut_mem [int];
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] ref_buf [64];
    bit            ref_dirty [64];
    logic [AW-1:0] ref_ptr = '0;

    // Capture array writes as the array would.
    always @(posedge clk) begin
        if (rst_n && arr_we) begin
            dut_mem[int'(arr_addr)] = arr_wdata;
            wr_cnt++;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int dirty_count();
        int c = 0;
        for (int i = 0; i < 64; i++) if (ref_dirty[i]) c++;
        return c;
    endfunction

    // One idle-cycle stimulus with the model following the priority of R10.
    task automatic drive(bit ld, logic [AW-1:0] a, bit bv, logic [DW-1:0] d, bit st);
        addr_load = ld; load_addr = a; byte_valid = bv; byte_data = d; rd_step = st;
        @(negedge clk);
        addr_load = 0; byte_valid = 0; rd_step = 0;
        if (ld) ref_ptr = a;
        else if (bv) begin
            ref_buf[ref_ptr[PW-1:0]] = d;
            ref_dirty[ref_ptr[PW-1:0]] = 1'b1;
            ref_ptr = {ref_ptr[AW-1:PW], ref_ptr[PW-1:0] + 6'd1};
        end else if (st) ref_ptr = ref_ptr + 15'd1;
    endtask

    task automatic compare_mem(string req);
        int bad = 0;
        foreach (ref_mem[k]) if (!dut_mem.exists(k) || dut_mem[k] !== ref_mem[k]) bad++;
        chk(req, "array mismatches", bad, 0);
        chk(req, "array footprint", dut_mem.num(), ref_mem.num());
    endtask

    // Commit, optionally toggling every input while busy; checks R5-R8.
    task automatic do_commit(string req, bit inh, bit hammer);
        int cnt = 0;
        int pre = wr_cnt;
        int exp_w = inh ? 0 : dirty_count();
        logic [AW-1:0] page = ref_ptr;
        commit = 1; wr_inhibit = inh;
        do begin
            @(negedge clk);
            cnt++;
            commit = 0; wr_inhibit = 0;
            if (hammer && !done) begin
                addr_load = 1'($urandom); load_addr = AW'($urandom);
                byte_valid = 1'($urandom); byte_data = DW'($urandom);
                rd_step = 1'($urandom); commit = 1'($urandom);
            end
        end while (!done && cnt < 300);
        addr_load = 0; byte_valid = 0; rd_step = 0; commit = 0;
        chk(req, "commit-to-done cycles", cnt, inh ? 1 : 65);
        chk(req, "array writes", wr_cnt - pre, exp_w);
        if (!inh) for (int i = 0; i < 64; i++)
            if (ref_dirty[i]) ref_mem[int'({page[AW-1:PW], 6'(i)})] = ref_buf[i];
        for (int i = 0; i < 64; i++) ref_dirty[i] = 1'b0;
        @(negedge clk);
        chk(req, "done dropped", done, 0);
        chk(req, "pointer after commit", ptr, ref_ptr);
        compare_mem(req);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int i = 0; i < 64; i++) begin ref_buf[i] = '0; ref_dirty[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ptr", ptr, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "arr_we", arr_we, 0);
        do_commit("R1", 0, 0);

        // R2: load and in-page advance
        drive(1, 15'h1234, 0, 0, 0);
        chk("R2", "ptr after load", ptr, 15'h1234);
        drive(0, 0, 1, 8'hA1, 0); drive(0, 0, 1, 8'hB2, 0); drive(0, 0, 1, 8'hC3, 0);
        chk("R2", "ptr after 3 bytes", ptr, 15'h1237);
        do_commit("R2", 0, 0);
        chk("R9", "ptr last+1", ptr, 15'h1237);

        // R3: wrap at end of page
        drive(1, 15'h2A3E, 0, 0, 0);
        for (int i = 0; i < 4; i++) drive(0, 0, 1, DW'(8'h10 + i), 0);
        chk("R3", "ptr wrapped in page", ptr, 15'h2A02);
        do_commit("R3", 0, 0);

        // R4: overflow past 64 bytes
        drive(1, 15'h0100, 0, 0, 0);
        for (int i = 0; i < 70; i++) drive(0, 0, 1, DW'(i * 3 + 1), 0);
        chk("R4", "ptr after 70 bytes", ptr, 15'h0106);
        do_commit("R4", 0, 0);

        // R6, R7: inputs ignored while busy, then empty commit
        drive(1, 15'h4440, 0, 0, 0);
        drive(0, 0, 1, 8'h5A, 0); drive(0, 0, 1, 8'hA5, 0);
        do_commit("R6", 0, 1);
        do_commit("R7", 0, 0);

        // R8: inhibited commit discards the buffer
        drive(1, 15'h6000, 0, 0, 0);
        for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'hEE, 0);
        do_commit("R8", 1, 0);
        do_commit("R8", 0, 0);

        // R9: full-width step rolls over
        drive(1, 15'h7FFE, 0, 0, 0);
        drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1);
        chk("R9", "ptr rollover", ptr, 15'h0000);

        // R10: priority among simultaneous inputs
        drive(1, 15'h0BFF, 1, 8'h77, 1);
        chk("R10", "load beats byte", ptr, 15'h0BFF);
        do_commit("R10", 0, 0);
        drive(0, 0, 1, 8'h99, 1);
        chk("R10", "byte beats step", ptr, 15'h0BC0);
        do_commit("R10", 0, 0);

        // Random transactions: R2 R3 R4 R5 R8
        for (int it = 0; it < 30; it++) begin
            int n = $urandom_range(1, 140);
            drive(1, AW'($urandom_range(0, 32767)), 0, 0, 0);
            if ($urandom_range(0, 3) == 0) drive(0, 0, 0, 0, 1);
            for (int b = 0; b < n; b++) drive(0, 0, 1, DW'($urandom), 0);
            chk("R2", "random ptr", ptr, ref_ptr);
            do_commit("R5", $urandom_range(0, 7) == 0, (it % 3) == 0);
        end
        report();
    end
endmodule